// File: doc/BRIEF.md
# Aging-Aware Adaptive Hold Controller

This block steers a variable-latency multiplier whose partial-product columns are bypassed when multiplicand bits are zero. For each operand pattern it counts the zero bits of the multiplicand. It then decides whether the product settles within one clock or needs two. When the answer is two, it lowers the enable of the multiplier's input registers for exactly one cycle, so the same operands are held while the slow result settles.

Two judges run on every pattern. A loose one accepts a pattern as single-cycle when its zero count exceeds `N`. A strict one requires a count above `N+1`. A wear monitor counts the timing-error reports the datapath raises during each window of `WINDOW` completed operations. When a window's error count passes `ERR_THRESH`, the monitor sets a sticky aging flag. From then on the strict judge is used, so fewer patterns run in one cycle. A timing-error report on a pattern's first cycle also forces that pattern to be re-executed over two cycles.

Top module: `ahl_ctrl`

## Requirements
- R1: While `aged` is 0 and `op_valid` is 1, `fast_op` is 1 exactly when the number of zero bits in `operand` exceeds `N`.
- R2: While `aged` is 1 and `op_valid` is 1, `fast_op` is 1 exactly when the zero count exceeds `N+1`.
- R3: The judge in use is chosen by `aged` alone. The loose judge of R1 is used while it is 0, and the strict judge of R2 is used once it is 1.
- R4: On the first cycle of a valid pattern that `fast_op` marks single-cycle and that has no `timing_err`, `in_en` stays 1.
- R5: On the first cycle of a valid pattern that is judged two-cycle, `in_en` is 0. In the following cycle `in_en` is 1, whatever the inputs are in that cycle.
- R6: A `timing_err` pulse in the first cycle of a valid pattern forces `in_en` to 0 for that cycle, even when the pattern is judged single-cycle. The next cycle then completes the pattern.
- R7: While `op_valid` is 0, `in_en` is 1 and `fast_op` is 0. `timing_err` is not counted toward aging in such a cycle.
- R8: A cycle with `op_valid` and `in_en` both 1 completes an operation. Errors seen with `op_valid` are counted per window of `WINDOW` completions, and the count is cleared when a window closes. `aged` rises in the cycle after the count within one window exceeds `ERR_THRESH`.
- R9: Once `aged` is 1, it stays 1 until reset.
- R10: After reset, `aged` is 0 and no hold is pending, so an idle cycle shows `in_en` = 1 and `fast_op` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| operand | input | WIDTH | Multiplicand of the pattern under evaluation |
| op_valid | input | 1 | A pattern is presented this cycle |
| timing_err | input | 1 | Timing-error report from the datapath's error-detecting registers |
| in_en | output | 1 | Enable for the multiplier input registers (0 = hold operands) |
| fast_op | output | 1 | Current pattern judged to finish in one cycle |
| aged | output | 1 | Sticky aging indicator; selects the strict judge |

## Verification
The hardest state to reach from the ports is a window boundary that falls between error reports. An error count that would pass the threshold across two windows must not set `aged`, while the same number of errors inside one window must. The stimulus resets the controller to a known window phase. It injects errors just under the threshold, pads the window with clean single-cycle operations until it closes, and then injects errors again until the flag rises. Both judges are covered by sweeping every 8-bit multiplicand before and after aging.

// File: rtl/ahl_pkg.sv
package ahl_pkg;
    typedef enum logic {
        PATH_LOOSE  = 1'b0,
        PATH_STRICT = 1'b1
    } path_e;
endpackage

// File: rtl/ahl_zero_judge.sv
module ahl_zero_judge #(
    parameter int WIDTH = 16,
    parameter int N     = 7
) (
    input  logic [WIDTH-1:0] operand,
    output logic             fast_loose,
    output logic             fast_strict
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW:0] TH_LOOSE  = (CW+1)'(N);
    localparam logic [CW:0] TH_STRICT = (CW+1)'(N + 1);

    logic [CW:0] zeros;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < WIDTH; i++) begin
            zeros = zeros + {{CW{1'b0}}, ~operand[i]};
        end
        fast_loose  = zeros > TH_LOOSE;
        fast_strict = zeros > TH_STRICT;
    end

    // strict acceptance is a subset of loose acceptance (R2)
    always_comb begin
        assert_strict_subset_R2: assert (!fast_strict || fast_loose);
    end
endmodule

// File: rtl/ahl_wear_monitor.sv
module ahl_wear_monitor #(
    parameter int WINDOW     = 256,
    parameter int ERR_THRESH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_done,
    input  logic err_seen,
    output logic aged
);
    localparam int OCW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam int ECW = $clog2(ERR_THRESH + 2);
    localparam logic [OCW-1:0] OPS_LAST = OCW'(WINDOW - 1);
    localparam logic [ECW:0]   ERR_SAT  = (ECW+1)'(ERR_THRESH + 1);
    localparam logic [ECW:0]   ERR_LIM  = (ECW+1)'(ERR_THRESH);

    typedef struct packed {
        logic [OCW-1:0] ops;
        logic [ECW-1:0] errs;
        logic           aged;
    } mon_t;

    mon_t mon_d, mon_q;
    logic [ECW:0] err_sum;
    logic         wrap;

    always_comb begin
        mon_d   = mon_q;
        err_sum = {1'b0, mon_q.errs} + {{ECW{1'b0}}, err_seen};
        wrap    = op_done && (mon_q.ops == OPS_LAST);
        if (op_done) begin
            mon_d.ops = wrap ? '0 : mon_q.ops + 1'b1;
        end
        if (wrap) begin
            mon_d.errs = '0;
        end else begin
            mon_d.errs = (err_sum > ERR_SAT) ? ECW'(ERR_SAT) : ECW'(err_sum);
        end
        mon_d.aged = mon_q.aged || (err_sum > ERR_LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign aged = mon_q.aged;

    assert_aged_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        aged |=> aged);

    assert_aged_needs_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aged) |-> $past(err_seen));
endmodule

// File: rtl/ahl_hold_ctrl.sv
module ahl_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic fast_sel,
    input  logic timing_err,
    output logic in_en
);
    typedef struct packed {
        logic hold;
    } hold_t;

    hold_t st_d, st_q;
    logic  slow_req;

    always_comb begin
        slow_req   = op_valid && (!fast_sel || timing_err);
        in_en      = st_q.hold || !slow_req;
        st_d.hold  = !in_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_hold_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en |=> in_en);

    assert_fast_no_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && fast_sel && !timing_err) |-> in_en);

    assert_idle_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> in_en);
endmodule

// File: rtl/ahl_ctrl.sv
module ahl_ctrl #(
    parameter int WIDTH      = 16,
    parameter int N          = 7,
    parameter int WINDOW     = 256,
    parameter int ERR_THRESH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] operand,
    input  logic             op_valid,
    input  logic             timing_err,
    output logic             in_en,
    output logic             fast_op,
    output logic             aged
);
    import ahl_pkg::*;

    logic  fast_loose, fast_strict, fast_sel;
    logic  op_done, err_seen;
    path_e path;

    ahl_zero_judge #(.WIDTH(WIDTH), .N(N)) u_judge (
        .operand     (operand),
        .fast_loose  (fast_loose),
        .fast_strict (fast_strict)
    );

    ahl_wear_monitor #(.WINDOW(WINDOW), .ERR_THRESH(ERR_THRESH)) u_wear (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_done  (op_done),
        .err_seen (err_seen),
        .aged     (aged)
    );

    always_comb begin
        path     = aged ? PATH_STRICT : PATH_LOOSE;
        fast_sel = (path == PATH_STRICT) ? fast_strict : fast_loose;
        fast_op  = op_valid && fast_sel;
        op_done  = op_valid && in_en;
        err_seen = op_valid && timing_err;
    end

    ahl_hold_ctrl u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .fast_sel   (fast_sel),
        .timing_err (timing_err),
        .in_en      (in_en)
    );

    assert_fast_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fast_op |-> op_valid);

    assert_strict_when_aged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && fast_op) |-> fast_strict);
endmodule

// File: tb/tb_ahl_ctrl.sv
`timescale 1ns/1ps
module tb_ahl_ctrl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] operand = '0;
    logic         op_valid = 1'b0;
    logic         timing_err = 1'b0;
    logic         in_en, fast_op, aged;

    int nvec = 0;
    int nbad = 0;
    bit done_flag = 1'b0;

    // bench model state
    bit m_hold, m_aged;
    int m_ops, m_errs;

    always #2.5 clk = ~clk;

    ahl_ctrl #(.WIDTH(W), .N(3), .WINDOW(16), .ERR_THRESH(2)) dut (
        .clk(clk), .rst_n(rst_n), .operand(operand), .op_valid(op_valid),
        .timing_err(timing_err), .in_en(in_en), .fast_op(fast_op), .aged(aged)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; timing_err = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_hold = 0; m_aged = 0; m_ops = 0; m_errs = 0;
        #1;
        nvec++;
        // R10: reset state seen at the ports
        if (in_en !== 1'b1 || fast_op !== 1'b0 || aged !== 1'b0) begin
            nbad++;
            $display("FAIL R10 reset: in_en=%b fast_op=%b aged=%b expected 1 0 0",
                     in_en, fast_op, aged);
        end
    endtask

    task automatic step(input logic [W-1:0] a, input bit v, input bit e, input string tag);
        int  zeros, esum;
        bit  sel, exp_fast, stall, exp_en, done, wrap;
        @(negedge clk);
        operand = a; op_valid = v; timing_err = e;
        #1;
        zeros    = W - $countones(a);
        sel      = m_aged ? (zeros > 4) : (zeros > 3);
        exp_fast = v && sel;
        stall    = v && !m_hold && (!sel || e);
        exp_en   = !stall;
        nvec++;
        if (fast_op !== exp_fast) begin
            nbad++;
            $display("FAIL %s fast_op a=%h: got %b expected %b",
                     m_aged ? "R2" : "R1", a, fast_op, exp_fast);
        end
        if (in_en !== exp_en) begin
            nbad++;
            $display("FAIL %s in_en a=%h v=%b e=%b: got %b expected %b",
                     tag, a, v, e, in_en, exp_en);
        end
        if (aged !== m_aged) begin
            nbad++;
            $display("FAIL R8/R9 aged: got %b expected %b", aged, m_aged);
        end
        done = v && exp_en;
        esum = m_errs + ((v && e) ? 1 : 0);
        if (esum > 2) m_aged = 1;
        wrap = done && (m_ops == 15);
        if (done) m_ops = wrap ? 0 : m_ops + 1;
        m_errs = wrap ? 0 : esum;
        m_hold = stall;
    endtask

    // one full pattern: first cycle, plus the held cycle if a stall is expected
    task automatic op(input logic [W-1:0] a, input bit e, input string tag);
        step(a, 1'b1, e, tag);
        if (m_hold) step(a, 1'b1, 1'b0, "R5");
    endtask

    initial begin
        do_reset();
        // R7: idle cycles with errors and slow patterns
        for (int i = 0; i < 6; i++) step(8'hFF, 1'b0, 1'b1, "R7");
        // R1/R4/R5: loose judge over every multiplicand (R3: aged is 0)
        for (int a = 0; a < 256; a++) op(W'(a), 1'b0, "R4");
        // R5: held cycle ignores a change of pattern
        step(8'hFF, 1'b1, 1'b0, "R5");
        step(8'hFF, 1'b1, 1'b1, "R5");
        step(8'h00, 1'b1, 1'b0, "R4");

        // R8: window clearing between error bursts
        do_reset();
        op(8'h00, 1'b1, "R6");
        op(8'h00, 1'b1, "R6");
        for (int i = 0; i < 14; i++) op(8'h00, 1'b0, "R4");
        op(8'h01, 1'b1, "R6");
        for (int i = 0; i < 3; i++) step(8'h00, 1'b0, 1'b1, "R7");
        nvec++;
        if (aged !== 1'b0) begin
            nbad++;
            $display("FAIL R8 aged after window clear: got %b expected 0", aged);
        end
        op(8'h00, 1'b1, "R6");
        op(8'h00, 1'b1, "R6");
        step(8'h00, 1'b0, 1'b0, "R7");
        nvec++;
        if (aged !== 1'b1) begin
            nbad++;
            $display("FAIL R8 aged after threshold: got %b expected 1", aged);
        end
        // R2/R3: strict judge over every multiplicand
        for (int a = 0; a < 256; a++) op(W'(a), 1'b0, "R5");
        // R9: several clean windows keep the flag
        for (int i = 0; i < 40; i++) op(8'h00, 1'b0, "R9");
        nvec++;
        if (aged !== 1'b1) begin
            nbad++;
            $display("FAIL R9 aged dropped: got %b expected 1", aged);
        end
        // R10: reset clears the flag
        do_reset();
        op(8'h0F, 1'b0, "R3");
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            done_flag = 1'b1;
            nbad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule